// File: doc/BRIEF.md
# Watchdog and Cyclic-Sense Prescaler Control

This block holds the timing configuration for a watchdog and for a low-power wake-up scheme. Each write carries a target bit and a 3-bit code. Target 0 loads the watchdog divider code. Target 1 loads the code that selects the wake-up sensing interval. Every write, whatever its target, is answered one cycle later with a copy of the watchdog status word, which was sampled in the write cycle.

The watchdog half divides an incoming base tick by a ratio looked up from its code and emits a one-cycle period tick. The ratio applies only while the windowed watchdog mode is active. Otherwise the divider runs at ratio 1. A new code never cuts a period short: it is picked up when the count next reloads.

The wake half combines its stored code with one configuration bit that arrives from outside, and presents the result as a 4-bit interval selector. When the device enters a low-power state, the block records whether a high-side switch was on at that moment. If one was, the wake-up scheme is cyclic sensing. If none was, it is a timed forced wake-up.

Top module: `wdcs_prescaler`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `wd_code_o`, the low 3 bits of `cs_interval_o`, `wd_tick`, `rsp_valid`, `rsp_data` and `wake_cyclic` are all 0.
- R2: A write with `wr_sel`=0 loads `wr_code` into `wd_code_o` on the next clock edge. The cyclic-sense code (`cs_interval_o[2:0]`) does not change.
- R3: A write with `wr_sel`=1 loads `wr_code` into `cs_interval_o[2:0]` on the next clock edge. `wd_code_o` does not change.
- R4: While `window_mode` is 1 and `base_tick` is held high, `wd_tick` pulses for one cycle every N cycles. N is 1, 2, 4, 6, 8, 10, 12 or 14 for watchdog codes 0 through 7. A `wd_tick` pulse only ever follows a cycle in which `base_tick` was high.
- R5: A reload that happens while `window_mode` is 0 uses ratio 1, whatever code is stored.
- R6: A period that is already running finishes with the ratio it was loaded with. A newly written code first governs the period that starts at the next reload.
- R7: The cycle after a write, `rsp_valid` is 1 and `rsp_data` equals the `wd_status_in` value present during the write. At all other times `rsp_valid` is 0 and `rsp_data` holds its last value.
- R8: `cs_interval_o` is {`ext_cs_bit`, cyclic-sense code}. Its top bit follows `ext_cs_bit` within the same cycle.
- R9: On a cycle with `lp_enter`=1, `wake_cyclic` takes the value of `hs_any_on` (1 = cyclic sensing, 0 = timed forced wake-up). It holds that value until the next `lp_enter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe for the timing register |
| wr_sel | input | 1 | Write target: 0 watchdog, 1 cyclic sense |
| wr_code | input | 3 | Prescaler code to write |
| wd_status_in | input | STAT_W | Watchdog status word to return on a write |
| rsp_valid | output | 1 | Write response valid |
| rsp_data | output | STAT_W | Returned watchdog status word |
| base_tick | input | 1 | Base timebase tick for the watchdog divider |
| window_mode | input | 1 | Windowed watchdog mode active |
| wd_tick | output | 1 | Divided watchdog period tick |
| wd_code_o | output | 3 | Stored watchdog code |
| ext_cs_bit | input | 1 | Extra interval bit from the configuration register |
| cs_interval_o | output | 4 | Wake-up sensing interval selector |
| lp_enter | input | 1 | Low-power entry strobe |
| hs_any_on | input | 1 | At least one high-side switch is enabled |
| wake_cyclic | output | 1 | 1 = cyclic sensing, 0 = timed forced wake-up |

## Verification
Some properties are checked on every cycle by the assertions. These are the steering of each write to exactly one code field, the one-cycle write response and the status word it carries, the rule that a period tick only follows a base tick, the live top bit of the interval selector, and the hold of the wake decision between entries. Other properties can only be shown by the bench's scenarios. These are the divide ratios themselves, the ratio-1 fallback when the window mode is off, and the completion of an in-flight period at its old ratio after a rewrite. The bench measures these as tick-to-tick intervals, and also compares all outputs with its reference model on every clock, including runs with a sparse base tick.

// File: rtl/wdcs_pkg.sv
package wdcs_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = CODE_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {TGT_WDOG = 1'b0, TGT_CSENSE = 1'b1} tgt_e;
    typedef enum logic {WAKE_TIMED = 1'b0, WAKE_CYCLIC = 1'b1} wake_e;

    typedef struct packed {
        code_t wd;
        code_t cs;
    } prescale_cfg_t;

    // Reload value (ratio - 1): code 0 -> ratio 1, code k -> ratio 2k
    function automatic cnt_t reload_of(input code_t c);
        if (c == '0) return '0;
        return {c, 1'b0} - cnt_t'(1);
    endfunction
endpackage

// File: rtl/wdcs_regs.sv
module wdcs_regs
    import wdcs_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  tgt_e              wr_tgt,
    input  code_t             wr_code,
    input  logic [STAT_W-1:0] stat_in,
    output prescale_cfg_t     cfg,
    output logic              rsp_valid,
    output logic [STAT_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= wr_en;
            if (wr_en) begin
                rsp_data <= stat_in;
                if (wr_tgt == TGT_CSENSE) cfg.cs <= wr_code;
                else                      cfg.wd <= wr_code;
            end
        end
    end
endmodule

// File: rtl/wdcs_divider.sv
module wdcs_divider
    import wdcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  base_tick,
    input  logic  window_on,
    input  code_t code,
    output logic  tick
);
    cnt_t  cnt;
    code_t eff_code;

    // Outside windowed mode the divider falls back to code 0 (ratio 1)
    assign eff_code = window_on ? code : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= base_tick && (cnt == '0);
            if (base_tick) begin
                if (cnt == '0) cnt <= reload_of(eff_code);
                else           cnt <= cnt - cnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/wdcs_wake.sv
module wdcs_wake
    import wdcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_enter,
    input  logic              hs_any_on,
    input  logic              ext_bit,
    input  code_t             cs_code,
    output wake_e             mode,
    output logic [CODE_W:0]   interval
);
    assign interval = {ext_bit, cs_code};

    always_ff @(posedge clk) begin
        if (rst)           mode <= WAKE_TIMED;
        else if (lp_enter) mode <= hs_any_on ? WAKE_CYCLIC : WAKE_TIMED;
    end
endmodule

// File: rtl/wdcs_prescaler.sv
module wdcs_prescaler
    import wdcs_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [STAT_W-1:0] wd_status_in,
    output logic              rsp_valid,
    output logic [STAT_W-1:0] rsp_data,
    input  logic              base_tick,
    input  logic              window_mode,
    output logic              wd_tick,
    output logic [CODE_W-1:0] wd_code_o,
    input  logic              ext_cs_bit,
    output logic [CODE_W:0]   cs_interval_o,
    input  logic              lp_enter,
    input  logic              hs_any_on,
    output logic              wake_cyclic
);
    prescale_cfg_t cfg;
    wake_e         wmode;

    wdcs_regs #(.STAT_W(STAT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_tgt    (tgt_e'(wr_sel)),
        .wr_code   (wr_code),
        .stat_in   (wd_status_in),
        .cfg       (cfg),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    wdcs_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .window_on (window_mode),
        .code      (cfg.wd),
        .tick      (wd_tick)
    );

    wdcs_wake u_wake (
        .clk       (clk),
        .rst       (rst),
        .lp_enter  (lp_enter),
        .hs_any_on (hs_any_on),
        .ext_bit   (ext_cs_bit),
        .cs_code   (cfg.cs),
        .mode      (wmode),
        .interval  (cs_interval_o)
    );

    assign wd_code_o   = cfg.wd;
    assign wake_cyclic = (wmode == WAKE_CYCLIC);
endmodule

// File: rtl/wdcs_checker.sv
module wdcs_checker
    import wdcs_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [CODE_W-1:0] wr_code,
    input logic [STAT_W-1:0] wd_status_in,
    input logic              rsp_valid,
    input logic [STAT_W-1:0] rsp_data,
    input logic              base_tick,
    input logic              wd_tick,
    input logic [CODE_W-1:0] wd_code_o,
    input logic              ext_cs_bit,
    input logic [CODE_W:0]   cs_interval_o,
    input logic              lp_enter,
    input logic              wake_cyclic
);
    AST_WD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (wd_code_o == $past(wr_code)));                        // R2
    AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel) |=> $stable(cs_interval_o[CODE_W-1:0]));                   // R2
    AST_CS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> (cs_interval_o[CODE_W-1:0] == $past(wr_code)));         // R3
    AST_WD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !wr_sel) |=> $stable(wd_code_o));                                  // R3
    AST_TICK_AFTER_BASE: assert property (@(posedge clk) disable iff (rst)
        wd_tick |-> $past(base_tick));                                                // R4
    AST_RSP_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rsp_valid && rsp_data == $past(wd_status_in)));                    // R7
    AST_RSP_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(wr_en));                                                  // R7
    AST_RSP_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rsp_data));                                                // R7
    AST_EXT_BIT_LIVE: assert property (@(posedge clk) disable iff (rst)
        cs_interval_o[CODE_W] == ext_cs_bit);                                         // R8
    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lp_enter |=> $stable(wake_cyclic));                                          // R9
endmodule

bind wdcs_prescaler wdcs_checker #(.STAT_W(STAT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_code       (wr_code),
    .wd_status_in  (wd_status_in),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data),
    .base_tick     (base_tick),
    .wd_tick       (wd_tick),
    .wd_code_o     (wd_code_o),
    .ext_cs_bit    (ext_cs_bit),
    .cs_interval_o (cs_interval_o),
    .lp_enter      (lp_enter),
    .wake_cyclic   (wake_cyclic)
);

// File: tb/wdcs_prescaler_tb.sv
module wdcs_prescaler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STAT_W     = 8;
    localparam int WD_LIMIT   = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [2:0]        wr_code = '0;
    logic [STAT_W-1:0] wd_status_in = '0;
    logic              rsp_valid;
    logic [STAT_W-1:0] rsp_data;
    logic              base_tick = 1'b0;
    logic              window_mode = 1'b0;
    logic              wd_tick;
    logic [2:0]        wd_code_o;
    logic              ext_cs_bit = 1'b0;
    logic [3:0]        cs_interval_o;
    logic              lp_enter = 1'b0;
    logic              hs_any_on = 1'b0;
    logic              wake_cyclic;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdcs_prescaler #(.STAT_W(STAT_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
        .wd_status_in(wd_status_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .base_tick(base_tick), .window_mode(window_mode), .wd_tick(wd_tick),
        .wd_code_o(wd_code_o), .ext_cs_bit(ext_cs_bit), .cs_interval_o(cs_interval_o),
        .lp_enter(lp_enter), .hs_any_on(hs_any_on), .wake_cyclic(wake_cyclic)
    );

    // Divide ratio table from the requirement (R4)
    function automatic int ratio_tab(input int code);
        case (code)
            0: return 1;   1: return 2;   2: return 4;   3: return 6;
            4: return 8;   5: return 10;  6: return 12;  default: return 14;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int              m_wd, m_cs, m_remain;
    bit              m_tick, m_rv, m_wake;
    int              m_rd;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_wd = 0; m_cs = 0; m_remain = 0; m_tick = 0; m_rv = 0; m_rd = 0; m_wake = 0;
        end else begin
            m_tick = base_tick && (m_remain == 0);
            if (base_tick) begin
                if (m_remain == 0) m_remain = ratio_tab(window_mode ? m_wd : 0) - 1;
                else               m_remain = m_remain - 1;
            end
            m_rv = wr_en;
            if (wr_en) begin
                m_rd = int'(wd_status_in);
                if (wr_sel) m_cs = int'(wr_code);
                else        m_wd = int'(wr_code);
            end
            if (lp_enter) m_wake = hs_any_on;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(wd_tick == m_tick, "R4 model wd_tick", int'(wd_tick), int'(m_tick));
            check(int'(wd_code_o) == m_wd, "R2 model wd_code", int'(wd_code_o), m_wd);
            check(int'(cs_interval_o) == (int'(ext_cs_bit) * 8 + m_cs), "R8 model cs_interval",
                  int'(cs_interval_o), int'(ext_cs_bit) * 8 + m_cs);
            check(rsp_valid == m_rv, "R7 model rsp_valid", int'(rsp_valid), int'(m_rv));
            check(int'(rsp_data) == m_rd, "R7 model rsp_data", int'(rsp_data), m_rd);
            check(wake_cyclic == m_wake, "R9 model wake_cyclic", int'(wake_cyclic), int'(m_wake));
        end
    end

    always @(posedge clk) begin
        if (cycles > WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic write_reg(input logic sel, input logic [2:0] code, input logic [STAT_W-1:0] st);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_code = code; wd_status_in = st;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic next_tick(output time t);
        do @(negedge clk); while (!wd_tick);
        t = $time;
    endtask

    initial begin
        time t0, t1, t2, t3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while in reset
        check(wd_code_o == 3'd0 && cs_interval_o[2:0] == 3'd0, "R1 codes in reset",
              int'(wd_code_o) + int'(cs_interval_o[2:0]), 0);
        check(!wd_tick && !rsp_valid && rsp_data == '0 && !wake_cyclic, "R1 outputs in reset",
              int'({wd_tick, rsp_valid, |rsp_data, wake_cyclic}), 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(wd_code_o == 3'd0 && !wd_tick && !rsp_valid && !wake_cyclic, "R1 after release",
              int'({wd_code_o, wd_tick, rsp_valid, wake_cyclic}), 0);

        // R4 ratio table with windowed mode, R2/R3 steering interleaved
        window_mode = 1'b1; base_tick = 1'b1;
        for (int c = 0; c < 8; c++) begin
            write_reg(1'b0, 3'(c), STAT_W'(8'h10 + c));
            write_reg(1'b1, 3'(7 - c), STAT_W'(8'h40 + c));
            @(negedge clk);
            check(int'(wd_code_o) == c, "R3 wd code kept on cs write", int'(wd_code_o), c);
            check(int'(cs_interval_o[2:0]) == 7 - c, "R3 cs code loaded", int'(cs_interval_o[2:0]), 7 - c);
            next_tick(t0); next_tick(t1); next_tick(t2);
            check((t2 - t1) / CLK_PERIOD == ratio_tab(c), "R4 period for code",
                  int'((t2 - t1) / CLK_PERIOD), ratio_tab(c));
        end

        // R2: watchdog write leaves cs code unchanged
        write_reg(1'b0, 3'd5, 8'h21);
        @(negedge clk);
        check(int'(cs_interval_o[2:0]) == 0 && wd_code_o == 3'd5, "R2 cs kept on wd write",
              int'(cs_interval_o[2:0]), 0);

        // R5: window off forces ratio 1
        window_mode = 1'b0;
        next_tick(t0); next_tick(t1); next_tick(t2);
        check((t2 - t1) / CLK_PERIOD == 1, "R5 ratio 1 when window off", int'((t2 - t1) / CLK_PERIOD), 1);
        window_mode = 1'b1;

        // R6: rewrite mid-period
        write_reg(1'b0, 3'd7, 8'h33);
        next_tick(t0); next_tick(t0); next_tick(t1);
        write_reg(1'b0, 3'd1, 8'h34);
        next_tick(t2); next_tick(t3);
        check((t2 - t1) / CLK_PERIOD == 14, "R6 running period keeps old ratio", int'((t2 - t1) / CLK_PERIOD), 14);
        check((t3 - t2) / CLK_PERIOD == 2, "R6 new ratio at next reload", int'((t3 - t2) / CLK_PERIOD), 2);

        // Sparse base tick with ratio 4 (R4 via model compare)
        write_reg(1'b0, 3'd2, 8'h35);
        for (int i = 0; i < 90; i++) begin
            @(posedge clk); #1; base_tick = (i % 3 == 0);
        end
        base_tick = 1'b0;

        // R7: write response
        write_reg(1'b1, 3'd3, 8'h5C);
        @(negedge clk);
        check(rsp_valid && rsp_data == 8'h5C, "R7 response after write", int'(rsp_data), 8'h5C);
        @(negedge clk);
        check(!rsp_valid && rsp_data == 8'h5C, "R7 response drops and holds", int'(rsp_valid), 0);

        // R8: interval selector
        write_reg(1'b1, 3'b101, 8'h60);
        @(posedge clk); #1; ext_cs_bit = 1'b1;
        @(negedge clk);
        check(cs_interval_o == 4'b1101, "R8 interval with ext bit", int'(cs_interval_o), 13);
        @(posedge clk); #1; ext_cs_bit = 1'b0;
        @(negedge clk);
        check(cs_interval_o == 4'b0101, "R8 interval without ext bit", int'(cs_interval_o), 5);

        // R9: wake decision latched on low-power entry
        @(posedge clk); #1; hs_any_on = 1'b1; lp_enter = 1'b1;
        @(posedge clk); #1; lp_enter = 1'b0; hs_any_on = 1'b0;
        @(negedge clk);
        check(wake_cyclic, "R9 cyclic when switch on", int'(wake_cyclic), 1);
        repeat (3) @(negedge clk);
        check(wake_cyclic, "R9 held without entry", int'(wake_cyclic), 1);
        @(posedge clk); #1; lp_enter = 1'b1;
        @(posedge clk); #1; lp_enter = 1'b0;
        @(negedge clk);
        check(!wake_cyclic, "R9 timed when no switch on", int'(wake_cyclic), 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule